// File: doc/BRIEF.md
# Dial Pulse and Flash Sequencer

This block turns a 4-bit telephone digit code into a burst of loop-disconnect pulses on a single line-control output. A short line break (flash) and a silent waiting interval (pause) can also be timed. The output is high for the make (loop closed) state and low for the break (loop open) state. Every duration is counted in ticks of a timing strobe that the surrounding clock logic supplies, nominally one tick per millisecond. One pulse period is 100 ticks at the slow rate and 50 ticks at the fast rate.

Software drives the block through a small write port. A 3-bit selector picks the target and a 4-bit data word carries the value. Selector 0 starts a digit. Selector 1 sets the mode: bit 0 selects the fast rate and bit 1 selects the short-make ratio. Selector 2 sets the inter-digit gap, selector 3 the flash length and selector 4 the pause length. Selector 5 is the command word: bit 0 starts a flash and bit 1 starts a pause. Selector 6 sets the interrupt mask in bit 0. When an operation finishes, a done flag rises and stays up until a read strobe clears it. While a digit is in progress, two active-low mute outputs silence the receive and transmit audio paths.

Top module: `dial_pulse_seq`

## Requirements
- R1: After reset, dp_out is 1, both mute outputs are 1, done_flag and irq are 0 and all status outputs are 0. The defaults are: slow rate, 40:60 ratio, gap code 8, flash code 6, pause code 4 and mask 0.
- R2: Writing code n (1 to 15) to selector 0 produces exactly n break pulses on dp_out. Each period starts with its break.
- R3: The break and make lengths in ticks are 60/40 (mode 0), 67/33 (mode bit 1), 30/20 (mode bit 0) and 33/17 (both mode bits set).
- R4: After the last make, dp_out stays high for the gap code times 94 ticks. The operation then ends.
- R5: A flash holds dp_out low for the flash code times 94 ticks.
- R6: A pause keeps dp_out high for the pause code times 1000 ticks.
- R7: Writing code 0 to the digit, gap, flash or pause selector has no effect. No operation starts and the stored value is kept.
- R8: While any operation is running, all writes are ignored, both new codes and configuration changes.
- R9: The done flag is set when a digit, flash or pause ends, and it is cleared by rd_clr. If both happen in the same cycle, the set wins. irq equals the done flag ANDed with the mask bit.
- R10: rx_mute_n and tx_mute_n are 0 for the whole digit, including the gap, and are 1 at all other times (idle, flash, pause).
- R11: st_dial, st_flash and st_pause are each 1 exactly while their own operation runs.
- R12: While hook_off is 0, no digit, flash or pause can start.
- R13: A duration advances only on cycles where tick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing strobe, one per duration unit |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target selector |
| wr_data | input | 4 | Write data |
| rd_clr | input | 1 | Read strobe that clears the done flag |
| hook_off | input | 1 | Hook switch status, 1 = off hook |
| dp_out | output | 1 | Line control, 1 = make, 0 = break |
| rx_mute_n | output | 1 | Receive mute, active low |
| tx_mute_n | output | 1 | Transmit mute, active low |
| done_flag | output | 1 | Operation-complete flag |
| irq | output | 1 | Masked completion request |
| st_dial | output | 1 | Digit in progress |
| st_flash | output | 1 | Flash in progress |
| st_pause | output | 1 | Pause in progress |

## Verification
The hardest situation to reach from the ports is a write that arrives in the middle of a digit. It must change neither the pulse count nor the break and make lengths of that digit or of the next one. The stimulus injects a new digit code and a new mode word ten cycles into a running two-pulse digit. It then checks the pulse count and the run lengths of that digit. The following digit is run with a slowed tick, and its break length shows that the slow, 40:60 mode survived. The same slowed-tick digit also shows that durations count ticks, not clock cycles.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BRK   = 3'd1,
    ST_MAK   = 3'd2,
    ST_GAP   = 3'd3,
    ST_FLASH = 3'd4,
    ST_PAUSE = 3'd5
  } dps_state_e;

  localparam logic [2:0] SEL_DIAL  = 3'd0;
  localparam logic [2:0] SEL_MODE  = 3'd1;
  localparam logic [2:0] SEL_GAP   = 3'd2;
  localparam logic [2:0] SEL_FLASH = 3'd3;
  localparam logic [2:0] SEL_PAUSE = 3'd4;
  localparam logic [2:0] SEL_CMD   = 3'd5;
  localparam logic [2:0] SEL_MASK  = 3'd6;

  typedef struct packed {
    logic       fast;
    logic       short_mk;
    logic [3:0] gap;
    logic [3:0] flash;
    logic [3:0] pause;
  } dps_cfg_t;

endpackage

// File: rtl/dps_cfg.sv
module dps_cfg
  import dps_pkg::*;
#(
  parameter logic [3:0] GAP_DEF   = 4'd8,
  parameter logic [3:0] FLASH_DEF = 4'd6,
  parameter logic [3:0] PAUSE_DEF = 4'd4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [3:0] wr_data,
  input  logic       busy,
  output dps_cfg_t   cfg,
  output logic       irq_mask
);

  dps_cfg_t cfg_q, cfg_d;
  logic     mask_q, mask_d;
  logic     wr_ok;
  logic     nz;

  assign wr_ok = wr_en && !busy;
  assign nz    = (wr_data != 4'd0);

  always_comb begin
    cfg_d  = cfg_q;
    mask_d = mask_q;
    if (wr_ok) begin
      case (wr_sel)
        SEL_MODE: begin
          cfg_d.fast     = wr_data[0];
          cfg_d.short_mk = wr_data[1];
        end
        SEL_GAP:   if (nz) cfg_d.gap   = wr_data;
        SEL_FLASH: if (nz) cfg_d.flash = wr_data;
        SEL_PAUSE: if (nz) cfg_d.pause = wr_data;
        SEL_MASK:  mask_d = wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.fast     <= 1'b0;
      cfg_q.short_mk <= 1'b0;
      cfg_q.gap      <= GAP_DEF;
      cfg_q.flash    <= FLASH_DEF;
      cfg_q.pause    <= PAUSE_DEF;
      mask_q         <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      mask_q <= mask_d;
    end
  end

  assign cfg      = cfg_q;
  assign irq_mask = mask_q;

  // R7: the duration codes can never hold the prohibited value
  a_r7_codes_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.gap != 4'd0) && (cfg_q.flash != 4'd0) && (cfg_q.pause != 4'd0));

  // R8: configuration is frozen while an operation runs
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg_q) && $stable(mask_q)));

endmodule

// File: rtl/dps_timer.sv
module dps_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (tick && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = tick && (cnt_q == CNT_W'(1));

  // R13: without a tick the count does not move
  a_r13_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));

  // R13: each tick removes exactly one unit
  a_r13_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
#(
  parameter int PULSE_TICKS = 100,
  parameter int STEP_TICKS  = 94,
  parameter int SEC_TICKS   = 1000,
  parameter int CNT_W       = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dps_cfg_t         cfg,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [3:0]       wr_data,
  input  logic             hook_off,
  input  logic             rd_clr,
  input  logic             t_done,
  output logic             t_load,
  output logic [CNT_W-1:0] t_val,
  output logic             busy,
  output logic             dp_out,
  output logic             rx_mute_n,
  output logic             tx_mute_n,
  output logic             done_flag,
  output logic             st_dial,
  output logic             st_flash,
  output logic             st_pause
);

  localparam int PER_SLOW  = PULSE_TICKS;
  localparam int PER_FAST  = PULSE_TICKS / 2;
  localparam int BRK_SL_L  = (PER_SLOW * 3) / 5;
  localparam int BRK_SL_S  = (PER_SLOW * 2 + 1) / 3;
  localparam int BRK_FA_L  = (PER_FAST * 3) / 5;
  localparam int BRK_FA_S  = (PER_FAST * 2 + 1) / 3;
  localparam int MAK_SL_L  = PER_SLOW - BRK_SL_L;
  localparam int MAK_SL_S  = PER_SLOW - BRK_SL_S;
  localparam int MAK_FA_L  = PER_FAST - BRK_FA_L;
  localparam int MAK_FA_S  = PER_FAST - BRK_FA_S;

  dps_state_e       state_q, state_d;
  logic [3:0]       pulses_q, pulses_d;
  logic             flag_q, flag_d;
  logic             flag_set;
  logic             idle_ok;
  logic             go_dial, go_flash, go_pause;
  logic [CNT_W-1:0] brk_len, mak_len;
  logic [CNT_W-1:0] gap_len, flash_len, pause_len;

  assign idle_ok  = (state_q == ST_IDLE) && hook_off && wr_en;
  assign go_dial  = idle_ok && (wr_sel == SEL_DIAL) && (wr_data != 4'd0);
  assign go_flash = idle_ok && (wr_sel == SEL_CMD) && wr_data[0];
  assign go_pause = idle_ok && (wr_sel == SEL_CMD) && !wr_data[0] && wr_data[1];

  always_comb begin
    case ({cfg.fast, cfg.short_mk})
      2'b00:   begin brk_len = CNT_W'(BRK_SL_L); mak_len = CNT_W'(MAK_SL_L); end
      2'b01:   begin brk_len = CNT_W'(BRK_SL_S); mak_len = CNT_W'(MAK_SL_S); end
      2'b10:   begin brk_len = CNT_W'(BRK_FA_L); mak_len = CNT_W'(MAK_FA_L); end
      default: begin brk_len = CNT_W'(BRK_FA_S); mak_len = CNT_W'(MAK_FA_S); end
    endcase
  end

  assign gap_len   = CNT_W'(cfg.gap)   * CNT_W'(STEP_TICKS);
  assign flash_len = CNT_W'(cfg.flash) * CNT_W'(STEP_TICKS);
  assign pause_len = CNT_W'(cfg.pause) * CNT_W'(SEC_TICKS);

  always_comb begin
    state_d  = state_q;
    pulses_d = pulses_q;
    t_load   = 1'b0;
    t_val    = '0;
    flag_set = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go_dial) begin
          state_d  = ST_BRK;
          pulses_d = wr_data;
          t_load   = 1'b1;
          t_val    = brk_len;
        end else if (go_flash) begin
          state_d = ST_FLASH;
          t_load  = 1'b1;
          t_val   = flash_len;
        end else if (go_pause) begin
          state_d = ST_PAUSE;
          t_load  = 1'b1;
          t_val   = pause_len;
        end
      end
      ST_BRK: begin
        if (t_done) begin
          state_d = ST_MAK;
          t_load  = 1'b1;
          t_val   = mak_len;
        end
      end
      ST_MAK: begin
        if (t_done) begin
          t_load = 1'b1;
          if (pulses_q > 4'd1) begin
            state_d  = ST_BRK;
            pulses_d = pulses_q - 4'd1;
            t_val    = brk_len;
          end else begin
            state_d  = ST_GAP;
            pulses_d = 4'd0;
            t_val    = gap_len;
          end
        end
      end
      ST_GAP, ST_FLASH, ST_PAUSE: begin
        if (t_done) begin
          state_d  = ST_IDLE;
          flag_set = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    flag_d = flag_q;
    if (flag_set)    flag_d = 1'b1;
    else if (rd_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pulses_q <= 4'd0;
      flag_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      pulses_q <= pulses_d;
      flag_q   <= flag_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign st_dial   = (state_q == ST_BRK) || (state_q == ST_MAK) || (state_q == ST_GAP);
  assign st_flash  = (state_q == ST_FLASH);
  assign st_pause  = (state_q == ST_PAUSE);
  assign dp_out    = !((state_q == ST_BRK) || (state_q == ST_FLASH));
  assign rx_mute_n = !st_dial;
  assign tx_mute_n = !st_dial;
  assign done_flag = flag_q;

  // R9: the flag stays up until it is read
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !rd_clr) |=> flag_q);

  // R9: the flag only rises at the end of a running operation
  a_r9_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(state_q == ST_GAP || state_q == ST_FLASH || state_q == ST_PAUSE));

  // R2: a break is only ever produced with pulses left to send
  a_r2_break_has_count: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BRK) |-> (pulses_q != 4'd0));

  // R8: a running operation never gains extra pulses
  a_r8_no_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (pulses_q <= $past(pulses_q)));

  // R12: nothing leaves idle while on hook
  a_r12_hook_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !hook_off) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/dial_pulse_seq.sv
module dial_pulse_seq
  import dps_pkg::*;
#(
  parameter int PULSE_TICKS = 100,
  parameter int STEP_TICKS  = 94,
  parameter int SEC_TICKS   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [3:0] wr_data,
  input  logic       rd_clr,
  input  logic       hook_off,
  output logic       dp_out,
  output logic       rx_mute_n,
  output logic       tx_mute_n,
  output logic       done_flag,
  output logic       irq,
  output logic       st_dial,
  output logic       st_flash,
  output logic       st_pause
);

  localparam int MAX_TICKS = 15 * SEC_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[SYNC_STAGES-1];

  dps_cfg_t         cfg;
  logic             irq_mask;
  logic             busy;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_done;

  dps_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .busy     (busy),
    .cfg      (cfg),
    .irq_mask (irq_mask)
  );

  dps_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tick     (tick),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  dps_ctrl #(
    .PULSE_TICKS (PULSE_TICKS),
    .STEP_TICKS  (STEP_TICKS),
    .SEC_TICKS   (SEC_TICKS),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cfg       (cfg),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .hook_off  (hook_off),
    .rd_clr    (rd_clr),
    .t_done    (t_done),
    .t_load    (t_load),
    .t_val     (t_val),
    .busy      (busy),
    .dp_out    (dp_out),
    .rx_mute_n (rx_mute_n),
    .tx_mute_n (tx_mute_n),
    .done_flag (done_flag),
    .st_dial   (st_dial),
    .st_flash  (st_flash),
    .st_pause  (st_pause)
  );

  assign irq = done_flag && irq_mask;

  // R9: the request follows the flag only when unmasked
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> done_flag);

  // R10: mutes are released whenever the line is idle
  a_r10_mute_idle: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!st_dial && !st_flash && !st_pause) |-> (rx_mute_n && tx_mute_n));

endmodule

// File: tb/dial_pulse_seq_tb.sv
`timescale 1ns/1ps
module dial_pulse_seq_tb;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [2:0] wr_sel;
  logic [3:0] wr_data;
  logic       rd_clr;
  logic       hook_off;
  logic       dp_out, rx_mute_n, tx_mute_n, done_flag, irq;
  logic       st_dial, st_flash, st_pause;

  int errors = 0;
  int checks = 0;
  bit half_tick = 0;
  bit finished = 0;

  int falls, lowrun, highrun, total, muted, n_dial, n_flash, n_pause;

  dial_pulse_seq u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_clr(rd_clr), .hook_off(hook_off), .dp_out(dp_out),
    .rx_mute_n(rx_mute_n), .tx_mute_n(tx_mute_n), .done_flag(done_flag),
    .irq(irq), .st_dial(st_dial), .st_flash(st_flash), .st_pause(st_pause)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (half_tick) tick <= ~tick;
    else           tick <= 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] sel, input logic [3:0] data);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic clr_flag();
    @(negedge clk); rd_clr = 1;
    @(negedge clk); rd_clr = 0;
  endtask

  // start an operation and watch it until the done flag; optional mid-run writes
  task automatic run_op(input logic [2:0] sel, input logic [3:0] data, input bit inject);
    int phase = 0;
    logic prev = 1;
    falls = 0; lowrun = 0; highrun = 0; total = 0; muted = 0;
    n_dial = 0; n_flash = 0; n_pause = 0;
    do_wr(sel, data);
    while (!done_flag && total < 30000) begin
      if (!dp_out && prev) falls++;
      prev = dp_out;
      if (!dp_out) begin
        if (phase == 0) phase = 1;
        if (phase == 1) lowrun++;
        if (phase == 2) phase = 3;
      end else begin
        if (phase == 1) phase = 2;
        if (phase == 2) highrun++;
      end
      if (!rx_mute_n && !tx_mute_n) muted++;
      n_dial  += st_dial;
      n_flash += st_flash;
      n_pause += st_pause;
      total++;
      if (inject && total == 10) begin wr_en = 1; wr_sel = 3'd0; wr_data = 4'd5; end
      if (inject && total == 11) begin wr_en = 1; wr_sel = 3'd1; wr_data = 4'd3; end
      if (inject && total == 12) wr_en = 0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(dp_out == 1, "R1 dp_out", dp_out, 1);
    chk(rx_mute_n == 1 && tx_mute_n == 1, "R1 mutes", rx_mute_n, 1);
    chk(done_flag == 0 && irq == 0, "R1 flag", done_flag, 0);
    chk({st_dial, st_flash, st_pause} == 3'b000, "R1 status", {st_dial, st_flash, st_pause}, 0);
  endtask

  task automatic t_default_digit();
    run_op(3'd0, 4'd3, 0);
    chk(falls == 3, "R2 pulses digit 3", falls, 3);
    chk(lowrun == 60, "R3 break slow 40:60", lowrun, 60);
    chk(highrun == 40, "R3 make slow 40:60", highrun, 40);
    chk(total == 300 + 8*94, "R4 default gap", total, 300 + 8*94);
    chk(muted == total, "R10 muted whole digit", muted, total);
    chk(n_dial == total, "R11 st_dial", n_dial, total);
    chk(rx_mute_n == 1 && tx_mute_n == 1, "R10 mute released", rx_mute_n, 1);
    chk(done_flag == 1, "R9 flag set", done_flag, 1);
    chk(irq == 0, "R9 irq masked", irq, 0);
    do_wr(3'd6, 4'd1);
    chk(irq == 1, "R9 irq unmasked", irq, 1);
    clr_flag();
    chk(done_flag == 0 && irq == 0, "R9 flag cleared", done_flag, 0);
  endtask

  task automatic t_fast_short();
    do_wr(3'd1, 4'd3);
    do_wr(3'd2, 4'd1);
    run_op(3'd0, 4'd2, 0);
    chk(falls == 2, "R2 pulses digit 2", falls, 2);
    chk(lowrun == 33, "R3 break fast 33:67", lowrun, 33);
    chk(highrun == 17, "R3 make fast 33:67", highrun, 17);
    chk(total == 100 + 94, "R4 gap code 1", total, 194);
    clr_flag();
  endtask

  task automatic t_max_digit();
    do_wr(3'd1, 4'd1);
    run_op(3'd0, 4'd15, 0);
    chk(falls == 15, "R2 pulses digit 15", falls, 15);
    chk(lowrun == 30, "R3 break fast 40:60", lowrun, 30);
    chk(highrun == 20, "R3 make fast 40:60", highrun, 20);
    chk(total == 750 + 94, "R2 digit 15 length", total, 844);
    clr_flag();
  endtask

  task automatic t_prohibited();
    do_wr(3'd0, 4'd0);
    repeat (5) @(negedge clk);
    chk(st_dial == 0 && dp_out == 1, "R7 dial code 0 ignored", st_dial, 0);
    chk(rx_mute_n == 1 && done_flag == 0, "R7 no activity", rx_mute_n, 1);
    do_wr(3'd2, 4'd0);
    do_wr(3'd3, 4'd0);
    run_op(3'd0, 4'd1, 0);
    chk(total == 50 + 94, "R7 gap code 0 ignored", total, 144);
    clr_flag();
  endtask

  task automatic t_flash();
    run_op(3'd5, 4'd1, 0);
    chk(falls == 1, "R5 one break", falls, 1);
    chk(lowrun == 6*94, "R5 flash default", lowrun, 564);
    chk(total == 6*94, "R5 flash length", total, 564);
    chk(n_flash == total, "R11 st_flash", n_flash, total);
    chk(muted == 0, "R10 no mute in flash", muted, 0);
    clr_flag();
  endtask

  task automatic t_pause();
    do_wr(3'd4, 4'd0);
    do_wr(3'd4, 4'd1);
    run_op(3'd5, 4'd2, 0);
    chk(falls == 0, "R6 line stays made", falls, 0);
    chk(total == 1000, "R6 pause 1 s", total, 1000);
    chk(n_pause == total, "R11 st_pause", n_pause, total);
    chk(muted == 0, "R10 no mute in pause", muted, 0);
    clr_flag();
  endtask

  task automatic t_busy_writes();
    do_wr(3'd1, 4'd0);
    run_op(3'd0, 4'd2, 1);
    chk(falls == 2, "R8 code write ignored", falls, 2);
    chk(lowrun == 60 && highrun == 40, "R8 mode write ignored", lowrun, 60);
    chk(total == 200 + 94, "R8 digit length", total, 294);
    clr_flag();
    half_tick = 1;
    run_op(3'd0, 4'd1, 0);
    half_tick = 0;
    chk(lowrun >= 119 && lowrun <= 120, "R13 break on half tick", lowrun, 120);
    chk(total >= 2*(100+94) - 1 && total <= 2*(100+94), "R8 mode kept / R13 length", total, 388);
    clr_flag();
  endtask

  task automatic t_on_hook();
    hook_off = 0;
    do_wr(3'd0, 4'd3);
    do_wr(3'd5, 4'd1);
    repeat (5) @(negedge clk);
    chk(st_dial == 0 && st_flash == 0 && dp_out == 1, "R12 on hook blocks", st_dial, 0);
    chk(done_flag == 0, "R12 no completion", done_flag, 0);
    hook_off = 1;
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_clr = 0; hook_off = 1; tick = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_default_digit();
    t_fast_short();
    t_max_digit();
    t_prohibited();
    t_flash();
    t_pause();
    t_busy_writes();
    t_on_hook();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule